// File: doc/BRIEF.md
# 64b/66b Transmit Block Encoder

This block sits between the reconciliation side of a 10 Gb/s transmit path and the scrambler. Each cycle that `in_valid` is high it takes one 64-bit transfer (eight byte lanes, each lane with a control flag) and turns it into one 66-bit block. The block is a 2-bit sync header plus a 64-bit payload. The result appears on the registered outputs one clock later.

Payload bit 0 is the first bit on the line after the header. Every field is placed least significant bit first, with no reversal at any field boundary. This covers the 8-bit block type, each 7-bit control code and each 4-bit ordered-set code. Four kinds of word are encoded:
- words of pure data;
- words made only of idle and error characters;
- words that end a packet at any of the eight lane positions;
- words carrying a sequence or signal ordered set in both lane 0 and lane 4.

Any other word becomes an error block.

Top module: `enc66_encoder`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle where `in_valid` was high, and low in the cycle after a cycle where `in_valid` was low.
- R2: While `in_valid` is low, `out_hdr` and `out_payload` keep their previous values, whatever `in_data` and `in_ctrl` carry.
- R3: A word with all eight control flags low gives header 2'b01. The payload is the input word unchanged: lane i is taken from `in_data[8i+7:8i]` and placed at payload bits 8i+7..8i.
- R4: A word whose eight lanes are all control characters, each idle (0x07) or error (0xFE), gives header 2'b10 and type 0x1E in payload bits 7:0. The 7-bit code of lane j sits at bits 8+7j upward: idle is 0x00 and error is 0x1E.
- R5: A word with the terminate character 0xFD (control) in lane k must have data in all lanes below k and idle or error characters in all lanes above k. It gives header 2'b10 and a type chosen by k: 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1, 0xFF for k = 0..7. Data byte i (i<k) sits at bits 8+8i upward. Then come 7−k zero pad bits. The code of each lane j>k sits at bits 8+7j upward.
- R6: The terminate block keeps an error character in a trailing lane as code 0x1E at that lane's position. For k=0 with error in lane 1, that code occupies bits 21:15.
- R7: A word with ordered-set characters in lanes 0 and 4 and data in all other lanes gives header 2'b10 and type 0x55. Lanes 1..3 go to bits 15:8, 23:16, 31:24, and lanes 5..7 go to bits 47:40, 55:48, 63:56.
- R8: In the 0x55 block the sequence character 0x9C maps to O code 0x0 and the signal character 0x5C maps to O code 0xF. The lane-0 code sits in bits 35:32 and the lane-4 code in bits 39:36, with no nibble swap.
- R9: Any valid word matching none of R3, R4, R5 and R7 gives header 2'b10, type 0x1E and eight error codes 0x1E.
- R10: Whenever `out_valid` is high, `out_hdr` is either 2'b01 or 2'b10.
- R11: While `rst_n` is low, `out_valid` is 0, `out_hdr` is 2'b00 and `out_payload` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| in_valid | input | 1 | Transfer strobe; the word is encoded when high |
| in_data | input | 64 | Eight byte lanes, lane 0 in bits 7:0 |
| in_ctrl | input | 8 | Control flag per lane, bit i for lane i |
| out_valid | output | 1 | A new block is present on the outputs |
| out_hdr | output | 2 | Sync header, bit 0 transmitted first |
| out_payload | output | 64 | Block payload, bit 0 transmitted first |

## Verification
Pure data words include bytes that look like control characters (0x9C, 0x5C, 0xFD, 0xFE, 0x07). This shows that only the flag, not the byte value, selects pass-through. Terminate words are tried at lanes 0, 1, 3 and 7, some with error characters behind the terminate. Because the expected values are worked out by hand, these cases detect a misplaced pad, a code placed at the wrong offset, or a code reversed inside its 7-bit field. Ordered-set words are tried with sequence/signal, signal/sequence and sequence/sequence pairs and with distinct data bytes. These separate the two O-code slots from one another and expose a swapped nibble. Near-miss words show that each fails into the error block: an unknown control byte, data after a terminate, a single ordered set, and a terminate with control below it.

// File: rtl/enc66_pkg.sv
package enc66_pkg;

  localparam int unsigned LANES   = 8;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CODE_W  = 7;
  localparam int unsigned OCODE_W = 4;
  localparam int unsigned TYPE_W  = 8;
  localparam int unsigned HDR_W   = 2;
  localparam int unsigned PAY_W   = LANES * BYTE_W;
  localparam int unsigned OSET_LANE = LANES / 2;

  // line characters seen on the reconciliation side
  localparam logic [BYTE_W-1:0] CH_IDLE = 8'h07;
  localparam logic [BYTE_W-1:0] CH_ERR  = 8'hFE;
  localparam logic [BYTE_W-1:0] CH_TERM = 8'hFD;
  localparam logic [BYTE_W-1:0] CH_SEQ  = 8'h9C;
  localparam logic [BYTE_W-1:0] CH_SIG  = 8'h5C;

  // payload field codes
  localparam logic [CODE_W-1:0]  CC_IDLE = 7'h00;
  localparam logic [CODE_W-1:0]  CC_ERR  = 7'h1E;
  localparam logic [OCODE_W-1:0] OC_SEQ  = 4'h0;
  localparam logic [OCODE_W-1:0] OC_SIG  = 4'hF;

  localparam logic [HDR_W-1:0]  HDR_DATA = 2'b01;
  localparam logic [HDR_W-1:0]  HDR_CTRL = 2'b10;
  localparam logic [TYPE_W-1:0] BT_FILL  = 8'h1E;
  localparam logic [TYPE_W-1:0] BT_OSET2 = 8'h55;

  typedef struct packed {
    logic               is_data;
    logic               is_fill;
    logic               is_term;
    logic               is_oset;
    logic [CODE_W-1:0]  ccode;
    logic [OCODE_W-1:0] ocode;
  } lane_info_t;

  function automatic logic [TYPE_W-1:0] term_type(input int unsigned pos);
    case (pos)
      0:       return 8'h87;
      1:       return 8'h99;
      2:       return 8'hAA;
      3:       return 8'hB4;
      4:       return 8'hCC;
      5:       return 8'hD2;
      6:       return 8'hE1;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [PAY_W-1:0] err_block();
    logic [PAY_W-1:0] p;
    p = '0;
    p[TYPE_W-1:0] = BT_FILL;
    for (int j = 0; j < LANES; j++) p[TYPE_W + CODE_W*j +: CODE_W] = CC_ERR;
    return p;
  endfunction

endpackage

// File: rtl/enc66_lane_class.sv
module enc66_lane_class
  import enc66_pkg::*;
(
  input  logic [BYTE_W-1:0] lane_char,
  input  logic              lane_ctl,
  output lane_info_t        info
);

  always_comb begin
    info = '0;
    if (!lane_ctl) begin
      info.is_data = 1'b1;
    end else begin
      case (lane_char)
        CH_IDLE: begin info.is_fill = 1'b1; info.ccode = CC_IDLE; end
        CH_ERR:  begin info.is_fill = 1'b1; info.ccode = CC_ERR;  end
        CH_TERM: info.is_term = 1'b1;
        CH_SEQ:  begin info.is_oset = 1'b1; info.ocode = OC_SEQ; end
        CH_SIG:  begin info.is_oset = 1'b1; info.ocode = OC_SIG; end
        default: info = '0;  // unencodable control character
      endcase
    end
  end

endmodule

// File: rtl/enc66_fill_pack.sv
module enc66_fill_pack
  import enc66_pkg::*;
(
  input  lane_info_t [LANES-1:0] info,
  output logic                   hit,
  output logic [PAY_W-1:0]       payload
);

  always_comb begin
    hit     = 1'b1;
    payload = '0;
    payload[TYPE_W-1:0] = BT_FILL;
    for (int j = 0; j < LANES; j++) begin
      hit = hit & info[j].is_fill;
      payload[TYPE_W + CODE_W*j +: CODE_W] = info[j].ccode;
    end
  end

endmodule

// File: rtl/enc66_term_pack.sv
module enc66_term_pack
  import enc66_pkg::*;
(
  input  lane_info_t [LANES-1:0] info,
  input  logic [PAY_W-1:0]       data,
  output logic                   hit,
  output logic [PAY_W-1:0]       payload
);

  logic [LANES-1:0]            cand;
  logic [LANES-1:0][PAY_W-1:0] pay_pos;

  // one candidate layout per terminate position, evaluated in parallel
  for (genvar k = 0; k < LANES; k++) begin : g_pos
    logic             c_k;
    logic [PAY_W-1:0] p_k;

    always_comb begin
      c_k = info[k].is_term;
      p_k = '0;
      p_k[TYPE_W-1:0] = term_type(k);
      for (int i = 0; i < k; i++) begin
        c_k = c_k & info[i].is_data;
        p_k[TYPE_W + BYTE_W*i +: BYTE_W] = data[BYTE_W*i +: BYTE_W];
      end
      for (int j = k + 1; j < LANES; j++) begin
        c_k = c_k & info[j].is_fill;
        p_k[TYPE_W + CODE_W*j +: CODE_W] = info[j].ccode;
      end
    end

    assign cand[k]    = c_k;
    assign pay_pos[k] = p_k;
  end

  always_comb begin
    hit     = |cand;
    payload = '0;
    for (int k = 0; k < LANES; k++) begin
      if (cand[k]) payload = payload | pay_pos[k];
    end
  end

endmodule

// File: rtl/enc66_oset_pack.sv
module enc66_oset_pack
  import enc66_pkg::*;
(
  input  lane_info_t [LANES-1:0] info,
  input  logic [PAY_W-1:0]       data,
  output logic                   hit,
  output logic [PAY_W-1:0]       payload
);

  localparam int unsigned OC_POS = TYPE_W + BYTE_W*(OSET_LANE - 1);

  always_comb begin
    hit = info[0].is_oset & info[OSET_LANE].is_oset;
    for (int i = 1; i < LANES; i++) begin
      if (i != OSET_LANE) hit = hit & info[i].is_data;
    end
    payload = '0;
    payload[TYPE_W-1:0] = BT_OSET2;
    for (int i = 1; i < OSET_LANE; i++) begin
      payload[TYPE_W + BYTE_W*(i-1) +: BYTE_W] = data[BYTE_W*i +: BYTE_W];
    end
    payload[OC_POS +: OCODE_W]           = info[0].ocode;
    payload[OC_POS + OCODE_W +: OCODE_W] = info[OSET_LANE].ocode;
    for (int i = OSET_LANE + 1; i < LANES; i++) begin
      payload[BYTE_W*i +: BYTE_W] = data[BYTE_W*i +: BYTE_W];
    end
  end

endmodule

// File: rtl/enc66_encoder.sv
module enc66_encoder
  import enc66_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [PAY_W-1:0]   in_data,
  input  logic [LANES-1:0]   in_ctrl,
  output logic               out_valid,
  output logic [HDR_W-1:0]   out_hdr,
  output logic [PAY_W-1:0]   out_payload
);

  lane_info_t [LANES-1:0] info;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    enc66_lane_class u_cls (
      .lane_char (in_data[BYTE_W*i +: BYTE_W]),
      .lane_ctl  (in_ctrl[i]),
      .info      (info[i])
    );
  end

  logic             data_hit, fill_hit, term_hit, oset_hit;
  logic [PAY_W-1:0] fill_pay, term_pay, oset_pay;

  assign data_hit = (in_ctrl == '0);

  enc66_fill_pack u_fill (.info(info), .hit(fill_hit), .payload(fill_pay));
  enc66_term_pack u_term (.info(info), .data(in_data), .hit(term_hit), .payload(term_pay));
  enc66_oset_pack u_oset (.info(info), .data(in_data), .hit(oset_hit), .payload(oset_pay));

  // next-state selection
  logic [HDR_W-1:0] nxt_hdr;
  logic [PAY_W-1:0] nxt_pay;

  always_comb begin
    nxt_hdr = HDR_CTRL;
    if (data_hit) begin
      nxt_hdr = HDR_DATA;
      nxt_pay = in_data;
    end else if (fill_hit) begin
      nxt_pay = fill_pay;
    end else if (term_hit) begin
      nxt_pay = term_pay;
    end else if (oset_hit) begin
      nxt_pay = oset_pay;
    end else begin
      nxt_pay = err_block();
    end
  end

  // output register, loaded only on a valid transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_hdr     <= '0;
      out_payload <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hdr     <= nxt_hdr;
        out_payload <= nxt_pay;
      end
    end
  end

  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_hdr) && $stable(out_payload)));  // R2
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl == '0) |=> (out_hdr == HDR_DATA && out_payload == $past(in_data)));  // R3
  AST_T0_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[0] && in_data[BYTE_W-1:0] == CH_TERM && term_hit)
      |=> (out_payload[TYPE_W-1:0] == 8'h87 && out_payload[TYPE_W+CODE_W-1:TYPE_W] == '0));  // R5
  AST_OSET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oset_hit) |=> (out_payload[TYPE_W-1:0] == BT_OSET2 &&
      out_payload[PAY_W-1:BYTE_W*(OSET_LANE+1)] == $past(in_data[PAY_W-1:BYTE_W*(OSET_LANE+1)])));  // R7
  AST_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0({data_hit, fill_hit, term_hit, oset_hit}));  // R9
  AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(data_hit || fill_hit || term_hit || oset_hit))
      |=> (out_hdr == HDR_CTRL && out_payload == err_block()));  // R9
  AST_HDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hdr == HDR_DATA || out_hdr == HDR_CTRL));  // R10

endmodule

// File: tb/sim_enc66_encoder.sv
module sim_enc66_encoder;

  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  c;
    logic [1:0]  h;
    logic [63:0] p;
    logic [7:0]  r;
  } vec_t;

  function automatic logic [63:0] bench_err();
    logic [63:0] v;
    v = 64'h1E;
    for (int j = 0; j < 8; j++) v = v | (64'h1E << (8 + 7*j));
    return v;
  endfunction

  localparam logic [63:0] ERRB = bench_err();
  localparam int NV = 17;

  // R3 data, R4 fill, R5/R6 terminate, R7/R8 ordered sets, R9 fallback
  localparam vec_t VECS [NV] = '{
    '{64'h0123456789ABCDEF, 8'h00, 2'b01, 64'h0123456789ABCDEF, 8'd3},
    '{64'h9C5CFD07FE000000, 8'h00, 2'b01, 64'h9C5CFD07FE000000, 8'd3},
    '{64'h0707070707070707, 8'hFF, 2'b10, 64'h000000000000001E, 8'd4},
    '{64'h07070707070707FE, 8'hFF, 2'b10, 64'h0000000000001E1E, 8'd4},
    '{64'hFEFEFEFEFEFEFEFE, 8'hFF, 2'b10, ERRB,                 8'd4},
    '{64'h070707070707FEFD, 8'hFF, 2'b10, 64'h00000000000F0087, 8'd6},
    '{64'h07070707070707FD, 8'hFF, 2'b10, 64'h0000000000000087, 8'd5},
    '{64'hFD66554433221100, 8'h80, 2'b10, 64'h66554433221100FF, 8'd5},
    '{64'h0707FE07FDCCBBAA, 8'hF8, 2'b10, 64'h0000F000CCBBAAB4, 8'd5},
    '{64'h070707070707FD5A, 8'hFE, 2'b10, 64'h0000000000005A99, 8'd5},
    '{64'h0000005C0000009C, 8'h11, 2'b10, 64'h000000F000000055, 8'd8},
    '{64'h7766559C3322115C, 8'h11, 2'b10, 64'h7766550F33221155, 8'd7},
    '{64'h0000009C0000009C, 8'h11, 2'b10, 64'h0000000000000055, 8'd8},
    '{64'h0707070755070707, 8'hFF, 2'b10, ERRB,                 8'd9},
    '{64'h0707AA0707FD1111, 8'hDC, 2'b10, ERRB,                 8'd9},
    '{64'h000000000000009C, 8'h01, 2'b10, ERRB,                 8'd9},
    '{64'h070707070707FD07, 8'hFF, 2'b10, ERRB,                 8'd9}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_data;
  logic [7:0]  in_ctrl;
  logic        out_valid;
  logic [1:0]  out_hdr;
  logic [63:0] out_payload;

  int checks;
  int fails;
  bit done;

  enc66_encoder u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ctrl     (in_ctrl),
    .out_valid   (out_valid),
    .out_hdr     (out_hdr),
    .out_payload (out_payload)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_out(input string req, input logic ev, input logic [1:0] eh,
                           input logic [63:0] ep);
    checks++;
    if (out_valid !== ev || out_hdr !== eh || out_payload !== ep) begin
      fails++;
      $display("FAIL %s: actual v=%0b h=%b p=%h expected v=%0b h=%b p=%h",
               req, out_valid, out_hdr, out_payload, ev, eh, ep);
    end
  endtask

  task automatic apply(input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_ctrl  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    in_ctrl  = '0;
    repeat (3) @(negedge clk);
    check_out("R11 reset", 1'b0, 2'b00, 64'h0);
    rst_n = 1'b1;

    // table walk: one-cycle latency (R1), header legality (R10)
    for (int n = 0; n < NV; n++) begin
      apply(VECS[n].d, VECS[n].c);
      check_out($sformatf("R%0d/R1/R10 vec%0d", VECS[n].r, n), 1'b1, VECS[n].h, VECS[n].p);
    end

    // R2: inputs change with in_valid low, outputs must hold
    apply(64'h7766559C3322115C, 8'h11);
    in_data = 64'hDEADBEEFCAFEF00D;
    in_ctrl = 8'h00;
    @(negedge clk);
    check_out("R2 hold", 1'b0, 2'b10, 64'h7766550F33221155);
    in_ctrl = 8'hFF;
    @(negedge clk);
    check_out("R2 hold ctrl", 1'b0, 2'b10, 64'h7766550F33221155);

    // R1: back-to-back transfers emerge on consecutive cycles
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 64'h1111111111111111;
    in_ctrl  = 8'h00;
    @(negedge clk);
    check_out("R1 b2b first", 1'b1, 2'b01, 64'h1111111111111111);
    in_data = 64'h07070707070707FD;
    in_ctrl = 8'hFF;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R1 b2b second", 1'b1, 2'b10, 64'h0000000000000087);

    // R11: reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_out("R11 mid-run reset", 1'b0, 2'b00, 64'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule